// File: doc/BRIEF.md
# Head Positioning Step Sequencer

This block runs the positioning commands of a floppy-style disk controller: return to track zero, seek to a target track, and single steps (repeat last direction, inward, outward). It produces a direction level and a one-clock step pulse for the drive. It keeps the controller's track register. It reads a track-zero sensor input.

Steps are timed from an external one-millisecond tick. The step period comes from a two-bit rate code that is latched with the command. An optional verify phase adds a fixed head-settling delay after the last step. At the end of that delay it samples an external pass/fail input. A failed verify, or a return to zero that never finds the sensor, ends the command with a seek error.

A parameter swaps the two slowest rates for two fast ones (2 ms and 3 ms). The tick-count checks below assume the default table.

Top module: `head_step_seq`

## Requirements
- R1: The rate code sets the number of ms ticks between two consecutive step pulses. The same count runs from the last pulse to completion when verify is off. Code 0 gives 6, code 1 gives 12, code 2 gives 20 and code 3 gives 30.
- R2: `step_o` is high for exactly one clock. `dir_o` (1 = toward higher track numbers) holds the same value in the clock before a pulse and during the pulse.
- R3: Op code 0 (return to zero) pulses outward (`dir_o` = 0) until `track0_i` is seen high, then leaves `track_o` at 0 with no error. If the sensor is already high, no pulse is issued.
- R4: If return to zero has issued 255 pulses and `track0_i` is still low, the command completes with `seek_err_o` = 1 and issues no further pulse.
- R5: Op code 1 (seek) pulses toward `target_i` until `track_o` equals it. It issues |target − track| pulses and ends with `track_o` = target. It issues no pulse when they are already equal.
- R6: Op codes 2 (repeat last direction), 3 (inward, `dir_o` = 1) and 4 (outward, `dir_o` = 0) issue exactly one pulse. `track_o` moves by one in the pulse direction only when `upd_i` = 1 and is otherwise unchanged.
- R7: An outward single step with `upd_i` = 1 while `track_o` = 0 still issues the pulse, and `track_o` stays 0.
- R8: With `verify_i` = 1, completion comes 30 ms ticks after the last step period. `seek_err_o` then equals the inverse of `verify_ok_i` sampled at the end of the delay.
- R9: `busy_o` rises the clock after an accepted `cmd_valid_i` and stays high through the one-clock `done_o` pulse, then falls. `cmd_valid_i` while busy has no effect.
- R10: After reset, `busy_o`, `done_o`, `step_o`, `dir_o` and `seek_err_o` are 0 and `track_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-clock pulse per millisecond |
| cmd_valid_i | input | 1 | Start a command (taken only when idle) |
| cmd_op_i | input | 3 | 0 zero, 1 seek, 2 step, 3 in, 4 out; others finish at once |
| upd_i | input | 1 | Single steps update the track register |
| verify_i | input | 1 | Add settle delay and verify check |
| rate_i | input | 2 | Step rate code |
| target_i | input | TRACK_W | Seek target track |
| track0_i | input | 1 | Head-at-track-zero sensor |
| verify_ok_i | input | 1 | Verify outcome, sampled at end of settle |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Step direction, 1 = inward |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-clock completion pulse |
| seek_err_o | output | 1 | Last command failed |
| track_o | output | TRACK_W | Track register |

## Verification
The hardest case to reach is the return-to-zero give-up. It needs a sensor that never asserts through 255 full step periods. The bench models a physical head position that drives `track0_i`, and it has a stuck-sensor switch that holds the input low for that one directed run. The track register and the head position can also drift apart. Single steps with update off cause this, and the bench keeps a separate model of each so that later seeks and returns are predicted correctly. A second command is also pulsed in the middle of a seek to show that it is dropped.

// File: rtl/head_step_pkg.sv
package head_step_pkg;

  typedef enum logic [2:0] {
    OP_HOME = 3'd0,
    OP_SEEK = 3'd1,
    OP_STEP = 3'd2,
    OP_IN   = 3'd3,
    OP_OUT  = 3'd4
  } pos_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SETUP, S_PULSE, S_WAIT, S_SETTLE, S_FIN
  } seq_st_e;

  function automatic int unsigned rate_ms(input logic [1:0] code, input bit fast);
    unique case (code)
      2'd0:    rate_ms = 6;
      2'd1:    rate_ms = 12;
      2'd2:    rate_ms = fast ? 2 : 20;
      default: rate_ms = fast ? 3 : 30;
    endcase
  endfunction

endpackage

// File: rtl/step_tick_timer.sv
module step_tick_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && tick_i && (cnt_q == CNT_W'(1)) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= period_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0)); // R1

endmodule

// File: rtl/head_step_ctrl.sv
module head_step_ctrl
  import head_step_pkg::*;
#(
  parameter int TRACK_W       = 8,
  parameter int RESTORE_LIMIT = 255
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic               upd_i,
  input  logic               verify_i,
  input  logic [1:0]         rate_i,
  input  logic [TRACK_W-1:0] target_i,
  input  logic               track0_i,
  input  logic               verify_ok_i,
  input  logic               tmr_expire_i,
  output logic               tmr_start_o,
  output logic               tmr_settle_o,
  output logic [1:0]         rate_o,
  output logic               step_o,
  output logic               dir_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [TRACK_W-1:0] track_o
);
  localparam int STEP_CNT_W = $clog2(RESTORE_LIMIT + 1);
  localparam logic [STEP_CNT_W-1:0] LIMIT = STEP_CNT_W'(RESTORE_LIMIT);
  localparam logic [TRACK_W-1:0] TRACK_MAX = '1;

  seq_st_e              st_q, st_d;
  logic [2:0]           op_q;
  logic                 upd_q, vfy_q, dir_q, dir_d, err_q, stepped_q;
  logic                 go_step, fail;
  logic [1:0]           rate_q;
  logic [TRACK_W-1:0]   tgt_q, trk_q, trk_nx;
  logic [STEP_CNT_W-1:0] cnt_q;

  always_comb begin
    st_d         = st_q;
    tmr_start_o  = 1'b0;
    tmr_settle_o = 1'b0;
    go_step      = 1'b0;
    fail         = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid_i) st_d = S_CHECK;
      S_CHECK: begin
        case (op_q)
          OP_HOME: begin
            if (!track0_i) begin
              if (cnt_q == LIMIT) fail = 1'b1;
              else go_step = 1'b1;
            end
          end
          OP_SEEK: go_step = (trk_q != tgt_q);
          OP_STEP, OP_IN, OP_OUT: go_step = !stepped_q;
          default: go_step = 1'b0;
        endcase
        if (go_step) st_d = S_SETUP;
        else if (fail || !vfy_q) st_d = S_FIN;
        else begin
          st_d         = S_SETTLE;
          tmr_start_o  = 1'b1;
          tmr_settle_o = 1'b1;
        end
      end
      S_SETUP: st_d = S_PULSE;
      S_PULSE: begin
        st_d        = S_WAIT;
        tmr_start_o = 1'b1;
      end
      S_WAIT:   if (tmr_expire_i) st_d = S_CHECK;
      S_SETTLE: if (tmr_expire_i) st_d = S_FIN;
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_HOME, OP_OUT: dir_d = 1'b0;
      OP_IN:           dir_d = 1'b1;
      OP_SEEK:         dir_d = (tgt_q > trk_q);
      default:         dir_d = dir_q;
    endcase
  end

  // saturating move of the track register
  assign trk_nx = dir_q ? ((trk_q == TRACK_MAX) ? trk_q : trk_q + 1'b1)
                        : ((trk_q == '0) ? trk_q : trk_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      op_q      <= '0;
      upd_q     <= 1'b0;
      vfy_q     <= 1'b0;
      rate_q    <= '0;
      tgt_q     <= '0;
      trk_q     <= '0;
      dir_q     <= 1'b0;
      err_q     <= 1'b0;
      stepped_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      st_q <= st_d;
      case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q      <= cmd_op_i;
          upd_q     <= upd_i;
          vfy_q     <= verify_i;
          rate_q    <= rate_i;
          tgt_q     <= target_i;
          err_q     <= 1'b0;
          stepped_q <= 1'b0;
          cnt_q     <= '0;
        end
        S_CHECK: begin
          if (go_step) dir_q <= dir_d;
          if (op_q == OP_HOME && track0_i) trk_q <= '0;
          if (fail) err_q <= 1'b1;
        end
        S_PULSE: begin
          stepped_q <= 1'b1;
          if (cnt_q != LIMIT) cnt_q <= cnt_q + STEP_CNT_W'(1);
          if (op_q == OP_HOME || op_q == OP_SEEK || upd_q) trk_q <= trk_nx;
        end
        S_SETTLE: if (tmr_expire_i) err_q <= !verify_ok_i;
        default: ;
      endcase
    end
  end

  assign step_o  = (st_q == S_PULSE);
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = (st_q == S_FIN);
  assign dir_o   = dir_q;
  assign err_o   = err_q;
  assign track_o = trk_q;
  assign rate_o  = rate_q;

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R2
  AST_DIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $stable(dir_o)); // R2
  AST_RESTORE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && op_q == OP_HOME) |-> (cnt_q < LIMIT)); // R4
  AST_TRACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q inside {S_CHECK, S_PULSE}) |=> $stable(track_o)); // R6
  AST_SAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !dir_o && track_o == '0) |=> (track_o == '0)); // R7
  AST_BUSY_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i) |=> busy_o); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R9

endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
  import head_step_pkg::*;
#(
  parameter int TRACK_W       = 8,
  parameter int RESTORE_LIMIT = 255,
  parameter int SETTLE_MS     = 30,
  parameter bit FAST_RATES    = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ms_tick_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic               upd_i,
  input  logic               verify_i,
  input  logic [1:0]         rate_i,
  input  logic [TRACK_W-1:0] target_i,
  input  logic               track0_i,
  input  logic               verify_ok_i,
  output logic               step_o,
  output logic               dir_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               seek_err_o,
  output logic [TRACK_W-1:0] track_o
);
  localparam int MAX_MS = (SETTLE_MS > 30) ? SETTLE_MS : 30;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  logic             tmr_start, tmr_settle, tmr_expire;
  logic [1:0]       rate_q;
  logic [CNT_W-1:0] tmr_period;

  assign tmr_period = tmr_settle ? CNT_W'(SETTLE_MS)
                                 : CNT_W'(rate_ms(rate_q, FAST_RATES));

  head_step_ctrl #(
    .TRACK_W      (TRACK_W),
    .RESTORE_LIMIT(RESTORE_LIMIT)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .upd_i       (upd_i),
    .verify_i    (verify_i),
    .rate_i      (rate_i),
    .target_i    (target_i),
    .track0_i    (track0_i),
    .verify_ok_i (verify_ok_i),
    .tmr_expire_i(tmr_expire),
    .tmr_start_o (tmr_start),
    .tmr_settle_o(tmr_settle),
    .rate_o      (rate_q),
    .step_o      (step_o),
    .dir_o       (dir_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (seek_err_o),
    .track_o     (track_o)
  );

  step_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .period_i(tmr_period),
    .tick_i  (ms_tick_i),
    .expire_o(tmr_expire)
  );

  AST_NO_STEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> busy_o); // R9

endmodule

// File: tb/head_step_seq_tb_top.sv
module head_step_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ms_tick = 1'b0;
  logic [1:0] div_q;
  logic       cmd_valid = 1'b0, upd = 1'b0, vfy = 1'b0, vok = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] rate = '0;
  logic [7:0] tgt = '0;
  logic       track0;
  logic       step_o, dir_o, busy_o, done_o, seek_err_o;
  logic [7:0] track_o;

  int  tests = 0, fails = 0;
  int  head_pos = 5;
  bit  stuck = 1'b0;
  int  m_trk = 0;
  bit  m_dir = 1'b0;

  always #10 clk_i = ~clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; ms_tick <= 1'b0;
    end else begin
      div_q <= div_q + 2'd1; ms_tick <= (div_q == 2'd3);
    end
  end

  assign track0 = (head_pos == 0) && !stuck;

  head_step_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ms_tick_i(ms_tick), .cmd_valid_i(cmd_valid),
    .cmd_op_i(op), .upd_i(upd), .verify_i(vfy), .rate_i(rate), .target_i(tgt),
    .track0_i(track0), .verify_ok_i(vok), .step_o(step_o), .dir_o(dir_o),
    .busy_o(busy_o), .done_o(done_o), .seek_err_o(seek_err_o), .track_o(track_o)
  );

  function automatic int exp_ms(input int r);
    case (r)
      0: return 6;
      1: return 12;
      2: return 20;
      default: return 30;
    endcase
  endfunction

  function automatic int sat_move(input int v, input bit d);
    if (d) return (v == 255) ? 255 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input int c_op, input bit c_upd, input bit c_vfy, input int c_rate,
                         input int c_tgt, input bit c_vok, input bit poke);
    int nper, pulses, ticks, exp_pulses, exp_trk, cyc;
    bit exp_dir, exp_err, prev_dir, prev_step, got_done;
    nper = exp_ms(c_rate);
    exp_err = 1'b0;
    case (c_op)
      0: begin exp_pulses = stuck ? 255 : head_pos; exp_dir = 1'b0; exp_trk = 0; exp_err = stuck; end
      1: begin
        exp_pulses = (c_tgt > m_trk) ? c_tgt - m_trk : m_trk - c_tgt;
        exp_dir = (c_tgt > m_trk); exp_trk = c_tgt;
      end
      default: begin
        exp_pulses = 1;
        exp_dir = (c_op == 3) ? 1'b1 : (c_op == 4) ? 1'b0 : m_dir;
        exp_trk = c_upd ? sat_move(m_trk, exp_dir) : m_trk;
      end
    endcase
    if (c_vfy && !exp_err) exp_err = !c_vok;
    @(negedge clk_i);
    cmd_valid = 1'b1; op = 3'(c_op); upd = c_upd; vfy = c_vfy; rate = 2'(c_rate);
    tgt = 8'(c_tgt); vok = c_vok;
    @(negedge clk_i);
    cmd_valid = 1'b0;
    chk(busy_o, "R9 busy after command", int'(busy_o), 1);
    pulses = 0; ticks = 0; prev_dir = dir_o; prev_step = 1'b0; got_done = 1'b0;
    for (cyc = 0; cyc < 40000 && !got_done; cyc++) begin
      if (poke && cyc == 5) begin cmd_valid = 1'b1; op = 3'd4; upd = 1'b1; end
      if (poke && cyc == 6) cmd_valid = 1'b0;
      if (step_o) begin
        if (prev_step) chk(1'b0, "R2 pulse wider than one clock", 1, 0);
        chk(dir_o == exp_dir, "R2/R3/R5/R6 step direction", int'(dir_o), int'(exp_dir));
        chk(dir_o == prev_dir, "R2 direction setup", int'(dir_o), int'(prev_dir));
        if (pulses > 0) chk(ticks == nper, "R1 step period", ticks, nper);
        pulses++; ticks = 0;
        head_pos = sat_move(head_pos, dir_o);
      end else if (ms_tick) ticks++;
      if (!busy_o) chk(1'b0, "R9 busy dropped early", 0, 1);
      if (done_o) got_done = 1'b1;
      prev_dir = dir_o; prev_step = step_o;
      if (!got_done) @(negedge clk_i);
    end
    chk(got_done, "R9 command completes", int'(got_done), 1);
    chk(pulses == exp_pulses, "R3/R4/R5/R6 pulse count", pulses, exp_pulses);
    if (pulses > 0 && !(c_op == 0 && stuck))
      chk(ticks == nper + (c_vfy ? 30 : 0), "R1/R8 completion delay", ticks, nper + (c_vfy ? 30 : 0));
    chk(seek_err_o == exp_err, "R4/R8 seek error", int'(seek_err_o), int'(exp_err));
    chk(int'(track_o) == exp_trk, "R3/R5/R6/R7 track register", int'(track_o), exp_trk);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R9 idle after done", int'(busy_o), 0);
    m_trk = exp_trk;
    if (exp_pulses > 0) m_dir = exp_dir;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_7a11));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !step_o && !dir_o && !seek_err_o, "R10 reset outputs", int'(busy_o), 0);
    chk(track_o == 8'd0, "R10 reset track", int'(track_o), 0);

    run_cmd(0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);   // R3 home from track 5
    run_cmd(0, 1'b0, 1'b0, 1, 0, 1'b0, 1'b0);   // R3 already home
    run_cmd(3, 1'b1, 1'b0, 1, 0, 1'b0, 1'b0);   // R6 in with update
    run_cmd(2, 1'b0, 1'b0, 2, 0, 1'b0, 1'b0);   // R6 repeat, no update
    run_cmd(4, 1'b1, 1'b0, 3, 0, 1'b0, 1'b0);   // R6 out
    run_cmd(4, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);   // R7 out at zero
    run_cmd(1, 1'b0, 1'b1, 0, 7, 1'b1, 1'b0);   // R5 R8 verify pass
    run_cmd(1, 1'b0, 1'b0, 0, 7, 1'b0, 1'b0);   // R5 no move
    run_cmd(1, 1'b0, 1'b1, 1, 3, 1'b0, 1'b1);   // R8 verify fail, R9 poke ignored
    stuck = 1'b1;
    run_cmd(0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);   // R4 give up
    stuck = 1'b0;
    run_cmd(0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);   // R3 recover

    for (int i = 0; i < 30; i++) begin
      int r_op, r_tgt;
      r_op  = int'($urandom_range(0, 4));
      r_tgt = m_trk + int'($urandom_range(0, 24)) - 12;
      if (r_tgt < 0) r_tgt = 0;
      if (r_tgt > 255) r_tgt = 255;
      run_cmd(r_op, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
              int'($urandom_range(0, 3)), r_tgt, 1'($urandom_range(0, 1)), 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule